// File: doc/BRIEF.md
# Bus Cycle Stop and Trace Formatter

This block sits beside an 8-bit CPU that drives its low address byte and data on the same eight lines. The block watches the address latch strobe and the CPU clock, which it samples in its own clock domain. When the address latch strobe falls, it stores the low address byte and a 3-bit cycle status. On a later falling edge of the CPU clock, if a switch mask selects that status, it drives READY low. The CPU then holds its bus frozen in a wait state.

While the CPU is frozen, a formatter walks a format table that is fixed when the block is built. It produces one line of ASCII text that describes the frozen cycle. Each entry in the table is one of three kinds:
- a literal character,
- a selector for one hex nibble of the captured address and data,
- a selector for one status flag, which a small character map turns into a character.

Characters leave the block one at a time. Each one goes out with a one-clock strobe, and only after the downstream sink reports that it is ready. When the line is complete, the block raises a done output. An operator then presses continue, and the block releases READY so the CPU can run on. The serial transmitter and the display that consume the characters are outside this block.

Top module: `bus_stop_tracer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `ready` is 1, `tx_send` is 0 and `trace_done` is 0. Asserting `rst` during a trace releases the CPU.
- R2: On a falling edge of `ale`, the value on `bus_ad` is stored as address bits 7:0. The cycle status is stored as the 3-bit code {`io_m`,`s1`,`s0`}, with `io_m` as the most significant bit. The traced address is {`addr_hi`, stored byte}.
- R3: On a falling edge of `cpu_clk` while running, `ready` goes low in the next clock when `stop_mask[code]` is 1 for the stored status code. A mask of all zeros never stops the CPU.
- R4: Once stopped, `ready` stays low until `trace_done` and `cont` are both high. `ready` then returns to 1. A `cont` pulse that arrives before the line is finished has no effect.
- R5: While `ready` is high, the formatter is held idle: it sends no characters and `trace_done` stays 0. It starts from the first table entry each time the CPU stops.
- R6: A format entry from 0x01 to 0x7F is sent as that character. An entry of 0x00 ends the line and raises `trace_done`.
- R7: A format entry of 0x80+n (n = 0..7) sends nibble n of the word {8'h00, `bus_ad`, `addr_hi`, stored low address} as an uppercase hex digit: '0'-'9' are 0x30-0x39 and 'A'-'F' are 0x41-0x46.
- R8: A format entry of 0xC0+n sends entry (v*8 + n) of the flag character map, where v is flag bit n. The flag bits are: bit 0 = stored `io_m`, bit 1 = stored `s1`, bit 2 = stored `s0`, bit 3 = live `inta_n`, bits 7:4 = 0.
- R9: Each character is placed on `tx_char` with `tx_send` high for exactly one clock. A strobe is issued only if `tx_ready` was 1 in the previous clock. After each strobe, the formatter waits for `tx_ready` again.
- R10: After a release, the CPU is not stopped again until a new falling edge of `ale` has stored a fresh status.
- R11: The default format line is "A:" + address nibbles 3,2,1,0 + " D:" + nibbles 5,4 + " " + flags 0..7 + CR (0x0D) + LF (0x0A), then the end entry. In the default flag map, v=0 gives 'M','.','.','K' for flags 0-3 and v=1 gives 'I','X','Y','-'. Flags 4-7 give a space (0x20) for either value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address latch strobe, sampled |
| cpu_clk | input | 1 | CPU clock, sampled |
| bus_ad | input | 8 | Multiplexed low address / data lines |
| addr_hi | input | 8 | High address byte |
| io_m | input | 1 | Status: I/O versus memory |
| s1 | input | 1 | Status bit 1 |
| s0 | input | 1 | Status bit 0 |
| inta_n | input | 1 | Interrupt acknowledge, active low, shown as a flag |
| stop_mask | input | 8 | One bit per status code selecting a stop |
| cont | input | 1 | Continue request |
| tx_ready | input | 1 | Downstream sink can accept a character |
| ready | output | 1 | READY to the CPU, low freezes the bus |
| tx_char | output | 8 | ASCII character |
| tx_send | output | 1 | One-clock strobe for `tx_char` |
| trace_done | output | 1 | The line has been sent |

## Verification
The bench targets the following corner cases:
- **Hex digits A-F.** Addresses and data containing these digits catch a converter that is off by seven in its offset.
- **Both flag values.** Status patterns drive each flag through 0 and 1, which exposes a swapped index into the flag map.
- **Slow sink.** A sink that drops its ready for several clocks catches a strobe issued without the handshake or held for longer than one clock.
- **Early continue.** A continue press that arrives before the line is finished would cut the line short in a wrong design.
- **Repeated CPU clock edges.** CPU clock edges after a release, with no new address latch, would make a wrong design stop again on the same stale cycle.
- **Unselected status and reset mid-trace.** A status code whose mask bit is clear, and a reset during a trace, check that only the selected code stops the CPU and that reset releases it.

// File: rtl/bst_pkg.sv
package bst_pkg;

    localparam int CHAR_W      = 8;
    localparam int FMT_DEPTH   = 32;
    localparam int FLAG_N      = 8;
    localparam int FLAG_MAP_N  = 2 * FLAG_N;
    localparam int WORD_W      = 32;
    localparam int NIB_N       = WORD_W / 4;
    localparam int SEL_W       = $clog2(NIB_N);

    // Stored bus cycle status, io_m is the most significant bit of the code
    typedef struct packed {
        logic io_m;
        logic s1;
        logic s0;
    } cyc_stat_t;

    typedef enum logic [1:0] {
        FS_WAIT = 2'd0,
        FS_SEND = 2'd1,
        FS_DONE = 2'd2
    } fmt_state_e;

    typedef enum logic [1:0] {
        ENT_LIT  = 2'd0,
        ENT_NIB  = 2'd1,
        ENT_FLAG = 2'd2,
        ENT_BAD  = 2'd3
    } ent_kind_e;

    function automatic ent_kind_e classify(input logic [CHAR_W-1:0] e);
        if (!e[7])                  return ENT_LIT;
        else if (e[7:3] == 5'b10000) return ENT_NIB;
        else if (e[7:3] == 5'b11000) return ENT_FLAG;
        else                        return ENT_BAD;
    endfunction

    function automatic logic [CHAR_W-1:0] hex_char(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        else           return 8'h37 + {4'h0, n};
    endfunction

    // Default line: "A:" a3 a2 a1 a0 " D:" d1 d0 " " f0..f7 CR LF end
    function automatic logic [FMT_DEPTH*CHAR_W-1:0] default_fmt();
        logic [FMT_DEPTH*CHAR_W-1:0] r;
        r = '0;
        r[0*8  +: 8] = 8'h41;
        r[1*8  +: 8] = 8'h3A;
        r[2*8  +: 8] = 8'h83;
        r[3*8  +: 8] = 8'h82;
        r[4*8  +: 8] = 8'h81;
        r[5*8  +: 8] = 8'h80;
        r[6*8  +: 8] = 8'h20;
        r[7*8  +: 8] = 8'h44;
        r[8*8  +: 8] = 8'h3A;
        r[9*8  +: 8] = 8'h85;
        r[10*8 +: 8] = 8'h84;
        r[11*8 +: 8] = 8'h20;
        for (int i = 0; i < FLAG_N; i++) begin
            r[(12+i)*8 +: 8] = 8'hC0 + 8'(i);
        end
        r[20*8 +: 8] = 8'h0D;
        r[21*8 +: 8] = 8'h0A;
        r[22*8 +: 8] = 8'h00;
        r[31*8 +: 8] = 8'h2E;
        return r;
    endfunction

    // Flag map index = value*8 + flag number
    function automatic logic [FLAG_MAP_N*CHAR_W-1:0] default_flag_map();
        logic [FLAG_MAP_N*CHAR_W-1:0] m;
        for (int i = 0; i < FLAG_MAP_N; i++) begin
            m[i*8 +: 8] = 8'h20;
        end
        m[0*8  +: 8] = 8'h4D;
        m[1*8  +: 8] = 8'h2E;
        m[2*8  +: 8] = 8'h2E;
        m[3*8  +: 8] = 8'h4B;
        m[8*8  +: 8] = 8'h49;
        m[9*8  +: 8] = 8'h58;
        m[10*8 +: 8] = 8'h59;
        m[11*8 +: 8] = 8'h2D;
        return m;
    endfunction

endpackage

// File: rtl/bst_capture.sv
module bst_capture
    import bst_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ale,
    input  logic            cpu_clk,
    input  logic [7:0]      bus_ad,
    input  cyc_stat_t       stat_in,
    output logic [7:0]      addr_lo,
    output cyc_stat_t       stat_q,
    output logic            ale_fall,
    output logic            cclk_fall
);

    logic ale_q;
    logic cclk_q;

    assign ale_fall  = ale_q  & ~ale;
    assign cclk_fall = cclk_q & ~cpu_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q  <= 1'b0;
            cclk_q <= 1'b0;
        end else begin
            ale_q  <= ale;
            cclk_q <= cpu_clk;
        end
    end

    // Low address and status are valid on the trailing edge of the strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_lo <= '0;
            stat_q  <= '0;
        end else if (ale_fall) begin
            addr_lo <= bus_ad;
            stat_q  <= stat_in;
        end
    end

endmodule

// File: rtl/bst_stop_ctrl.sv
module bst_stop_ctrl
    import bst_pkg::*;
#(
    parameter int CODE_N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale_fall,
    input  logic              cclk_fall,
    input  cyc_stat_t         stat_q,
    input  logic [CODE_N-1:0] stop_mask,
    input  logic              fmt_done,
    input  logic              cont,
    output logic              ready
);

    logic armed;
    logic hit;

    assign hit = stop_mask[stat_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b1;
            armed <= 1'b0;
        end else begin
            if (!ready) begin
                if (fmt_done && cont) begin
                    ready <= 1'b1;
                end
            end else if (cclk_fall && armed && hit) begin
                ready <= 1'b0;
                armed <= 1'b0;
            end
            // A fresh capture re-arms, even in the cycle of a stop
            if (ale_fall) begin
                armed <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/bst_char_decode.sv
module bst_char_decode
    import bst_pkg::*;
#(
    parameter logic [FLAG_MAP_N*CHAR_W-1:0] FLAG_MAP = default_flag_map()
) (
    input  logic [CHAR_W-1:0] entry,
    input  logic [WORD_W-1:0] data_word,
    input  logic [FLAG_N-1:0] flags,
    output logic [CHAR_W-1:0] ch
);

    logic [SEL_W-1:0]       sel;
    logic [3:0]             nib;
    logic                   fval;
    logic [SEL_W:0]         map_idx;
    logic [NIB_N*4-1:0]     word_v;

    assign sel    = entry[SEL_W-1:0];
    assign word_v = data_word;
    assign nib    = word_v[{sel, 2'b00} +: 4];
    assign fval   = flags[sel];
    assign map_idx = {fval, sel};

    always_comb begin
        unique case (classify(entry))
            ENT_LIT:  ch = entry;
            ENT_NIB:  ch = hex_char(nib);
            ENT_FLAG: ch = FLAG_MAP[{map_idx, 3'b000} +: CHAR_W];
            default:  ch = 8'h3F;
        endcase
    end

endmodule

// File: rtl/bst_fmt.sv
module bst_fmt
    import bst_pkg::*;
#(
    parameter int                            DEPTH    = FMT_DEPTH,
    parameter logic [DEPTH*CHAR_W-1:0]       FMT      = default_fmt(),
    parameter logic [FLAG_MAP_N*CHAR_W-1:0]  FLAG_MAP = default_flag_map()
) (
    input  logic              clk,
    input  logic              hold,
    input  logic [WORD_W-1:0] data_word,
    input  logic [FLAG_N-1:0] flags,
    input  logic              tx_ready,
    output logic [CHAR_W-1:0] tx_char,
    output logic              tx_send,
    output logic              done
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    fmt_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [CHAR_W-1:0] entry;
    logic [CHAR_W-1:0] dec_ch;
    logic [CHAR_W-1:0] char_q;

    assign entry = FMT[{idx, 3'b000} +: CHAR_W];

    bst_char_decode #(
        .FLAG_MAP (FLAG_MAP)
    ) u_dec (
        .entry     (entry),
        .data_word (data_word),
        .flags     (flags),
        .ch        (dec_ch)
    );

    // Held idle while the CPU runs, so each stop begins at entry 0
    always_ff @(posedge clk) begin
        if (hold) begin
            state  <= FS_WAIT;
            idx    <= '0;
            char_q <= '0;
        end else begin
            unique case (state)
                FS_WAIT: begin
                    if (entry == '0) begin
                        state <= FS_DONE;
                    end else if (tx_ready) begin
                        char_q <= dec_ch;
                        state  <= FS_SEND;
                    end
                end
                FS_SEND: begin
                    idx <= idx + 1'b1;
                    if (idx == LAST) state <= FS_DONE;
                    else             state <= FS_WAIT;
                end
                FS_DONE: state <= FS_DONE;
                default: state <= FS_WAIT;
            endcase
        end
    end

    assign tx_send = (state == FS_SEND);
    assign done    = (state == FS_DONE);
    assign tx_char = char_q;

endmodule

// File: rtl/bus_stop_tracer.sv
module bus_stop_tracer
    import bst_pkg::*;
#(
    parameter int                                 DEPTH    = FMT_DEPTH,
    parameter logic [DEPTH*CHAR_W-1:0]            FMT      = default_fmt(),
    parameter logic [FLAG_MAP_N*CHAR_W-1:0]       FLAG_MAP = default_flag_map()
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ale,
    input  logic       cpu_clk,
    input  logic [7:0] bus_ad,
    input  logic [7:0] addr_hi,
    input  logic       io_m,
    input  logic       s1,
    input  logic       s0,
    input  logic       inta_n,
    input  logic [7:0] stop_mask,
    input  logic       cont,
    input  logic       tx_ready,
    output logic       ready,
    output logic [7:0] tx_char,
    output logic       tx_send,
    output logic       trace_done
);

    cyc_stat_t         stat_in;
    cyc_stat_t         stat_q;
    logic [7:0]        addr_lo;
    logic              ale_fall;
    logic              cclk_fall;
    logic [WORD_W-1:0] data_word;
    logic [FLAG_N-1:0] flags;

    assign stat_in = '{io_m: io_m, s1: s1, s0: s0};

    bst_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .ale       (ale),
        .cpu_clk   (cpu_clk),
        .bus_ad    (bus_ad),
        .stat_in   (stat_in),
        .addr_lo   (addr_lo),
        .stat_q    (stat_q),
        .ale_fall  (ale_fall),
        .cclk_fall (cclk_fall)
    );

    bst_stop_ctrl #(
        .CODE_N (8)
    ) u_stop (
        .clk       (clk),
        .rst       (rst),
        .ale_fall  (ale_fall),
        .cclk_fall (cclk_fall),
        .stat_q    (stat_q),
        .stop_mask (stop_mask),
        .fmt_done  (trace_done),
        .cont      (cont),
        .ready     (ready)
    );

    // Frozen bus carries data on bus_ad; upper byte of the word is unused
    assign data_word = {8'h00, bus_ad, addr_hi, addr_lo};
    assign flags     = {4'b0000, inta_n, stat_q.s0, stat_q.s1, stat_q.io_m};

    bst_fmt #(
        .DEPTH    (DEPTH),
        .FMT      (FMT),
        .FLAG_MAP (FLAG_MAP)
    ) u_fmt (
        .clk       (clk),
        .hold      (rst | ready),
        .data_word (data_word),
        .flags     (flags),
        .tx_ready  (tx_ready),
        .tx_char   (tx_char),
        .tx_send   (tx_send),
        .done      (trace_done)
    );

endmodule

// File: rtl/bus_stop_tracer_chk.sv
module bus_stop_tracer_chk (
    input logic       clk,
    input logic       rst,
    input logic       ready,
    input logic       tx_send,
    input logic       tx_ready,
    input logic       trace_done,
    input logic       cont,
    input logic [7:0] stop_mask
);

    assert_zero_mask_R3: assert property (@(posedge clk) disable iff (rst)
        (ready && stop_mask == 8'h00) |=> ready);

    assert_hold_stop_R4: assert property (@(posedge clk) disable iff (rst)
        (!ready && !(trace_done && cont)) |=> !ready);

    assert_release_R4: assert property (@(posedge clk) disable iff (rst)
        (!ready && trace_done && cont) |=> ready);

    assert_idle_running_R5: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(ready)) |-> (!tx_send && !trace_done));

    assert_strobe_width_R9: assert property (@(posedge clk) disable iff (rst)
        tx_send |=> !tx_send);

    assert_strobe_handshake_R9: assert property (@(posedge clk) disable iff (rst)
        tx_send |-> $past(tx_ready));

endmodule

bind bus_stop_tracer bus_stop_tracer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ready      (ready),
    .tx_send    (tx_send),
    .tx_ready   (tx_ready),
    .trace_done (trace_done),
    .cont       (cont),
    .stop_mask  (stop_mask)
);

// File: tb/bus_stop_tracer_tb.sv
`timescale 1ns/1ps
module bus_stop_tracer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale = 1'b0;
    logic       cpu_clk = 1'b0;
    logic [7:0] bus_ad = 8'h00;
    logic [7:0] addr_hi = 8'h00;
    logic       io_m = 1'b0;
    logic       s1 = 1'b0;
    logic       s0 = 1'b0;
    logic       inta_n = 1'b1;
    logic [7:0] stop_mask = 8'h00;
    logic       cont = 1'b0;
    logic       tx_ready = 1'b1;
    logic       ready;
    logic [7:0] tx_char;
    logic       tx_send;
    logic       trace_done;

    always #4 clk = ~clk;

    bus_stop_tracer u_dut (
        .clk        (clk),
        .rst        (rst),
        .ale        (ale),
        .cpu_clk    (cpu_clk),
        .bus_ad     (bus_ad),
        .addr_hi    (addr_hi),
        .io_m       (io_m),
        .s1         (s1),
        .s0         (s0),
        .inta_n     (inta_n),
        .stop_mask  (stop_mask),
        .cont       (cont),
        .tx_ready   (tx_ready),
        .ready      (ready),
        .tx_char    (tx_char),
        .tx_send    (tx_send),
        .trace_done (trace_done)
    );

    int  checks = 0;
    int  fails = 0;
    bit  finished = 0;

    // Sink model and character collector, all on the falling edge
    logic [7:0] got [64];
    int  got_n = 0;
    bit  slow_sink = 0;
    int  gap = 0;
    bit  prev_ready = 1;
    bit  prev_send = 0;
    int  proto_err = 0;

    always @(negedge clk) begin
        if (tx_send) begin
            if (!prev_ready) proto_err++;
            if (prev_send)   proto_err++;
            if (got_n < 64) got[got_n] = tx_char;
            got_n++;
        end
        prev_send = tx_send;
        if (tx_send && slow_sink) begin
            tx_ready = 1'b0;
            gap = 3;
        end else if (gap > 0) begin
            gap--;
            if (gap == 0) tx_ready = 1'b1;
        end
        prev_ready = tx_ready;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic bus_cycle(input logic [2:0] code, input logic [7:0] hi,
                             input logic [7:0] lo, input logic [7:0] dat);
        @(negedge clk);
        ale = 1'b1;
        bus_ad = lo;
        addr_hi = hi;
        {io_m, s1, s0} = code;
        tick(2);
        ale = 1'b0;
        tick(2);
        bus_ad = dat;
        cpu_clk = 1'b1;
        tick(2);
        cpu_clk = 1'b0;
        tick(2);
    endtask

    task automatic cpu_clk_only(input int n);
        for (int i = 0; i < n; i++) begin
            cpu_clk = 1'b1;
            tick(2);
            cpu_clk = 1'b0;
            tick(2);
        end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000; i++) begin
            if (trace_done) break;
            @(negedge clk);
        end
    endtask

    task automatic expect_line(input string s, input string req);
        chk(got_n == s.len(), req, "line length", got_n, s.len());
        for (int i = 0; i < s.len(); i++) begin
            if (i < got_n && i < 64)
                chk(got[i] == s[i], req, $sformatf("char %0d", i), got[i], s[i]);
        end
    endtask

    task automatic release_cpu();
        cont = 1'b1;
        @(negedge clk);
        cont = 1'b0;
    endtask

    // R1: reset state
    task automatic test_reset();
        do_reset();
        chk(ready == 1'b1, "R1", "ready after reset", ready, 1);
        chk(tx_send == 1'b0, "R1", "tx_send after reset", tx_send, 0);
        chk(trace_done == 1'b0, "R1", "trace_done after reset", trace_done, 0);
    endtask

    // R3: a zero mask never stops
    task automatic test_zero_mask();
        stop_mask = 8'h00;
        got_n = 0;
        for (int c = 0; c < 8; c++) begin
            bus_cycle(3'(c), 8'h40, 8'(c), 8'h55);
            chk(ready == 1'b1, "R3", $sformatf("zero mask code %0d", c), ready, 1);
        end
        chk(got_n == 0, "R5", "no chars while running", got_n, 0);
    endtask

    // R2 R3 R4 R5 R6 R7 R8 R9 R11: stop on code 3 with a slow sink
    task automatic test_trace_slow();
        stop_mask = 8'b0000_1000;
        slow_sink = 1;
        inta_n = 1'b1;
        got_n = 0;
        proto_err = 0;
        bus_cycle(3'b011, 8'h12, 8'hAB, 8'h3C);
        chk(ready == 1'b0, "R3", "stop on selected code", ready, 0);
        tick(4);
        cont = 1'b1;
        @(negedge clk);
        cont = 1'b0;
        tick(2);
        chk(ready == 1'b0, "R4", "early continue ignored", ready, 0);
        wait_done();
        chk(trace_done == 1'b1, "R6", "done at end marker", trace_done, 1);
        expect_line("A:12AB D:3C MXY-    \r\n", "R11");
        chk(proto_err == 0, "R9", "strobe handshake errors", proto_err, 0);
        tick(10);
        chk(ready == 1'b0, "R4", "held until continue", ready, 0);
        release_cpu();
        chk(ready == 1'b1, "R4", "released after continue", ready, 1);
        @(negedge clk);
        chk(trace_done == 1'b0, "R5", "formatter idle after release", trace_done, 0);
        slow_sink = 0;
    endtask

    // R10: no second stop without a new capture
    task automatic test_no_refreeze();
        int n0;
        n0 = got_n;
        cpu_clk_only(4);
        chk(ready == 1'b1, "R10", "stale status does not stop", ready, 1);
        bus_cycle(3'b010, 8'h00, 8'h01, 8'h02);
        chk(ready == 1'b1, "R3", "unselected code runs", ready, 1);
        chk(got_n == n0, "R5", "no chars while running", got_n, n0);
        release_cpu();
        bus_cycle(3'b011, 8'h12, 8'hAB, 8'h3C);
        chk(ready == 1'b0, "R10", "fresh capture stops again", ready, 0);
        cont = 1'b1;
        wait_done();
        tick(2);
        cont = 1'b0;
        chk(ready == 1'b1, "R4", "continue held releases at done", ready, 1);
    endtask

    // R2 R7 R8: other status and letters, fast sink
    task automatic test_fast_second();
        stop_mask = 8'b0001_0000;
        inta_n = 1'b0;
        tick(2);
        got_n = 0;
        proto_err = 0;
        bus_cycle(3'b100, 8'hF0, 8'h5E, 8'h9D);
        chk(ready == 1'b0, "R3", "stop on code 4", ready, 0);
        wait_done();
        expect_line("A:F05E D:9D I..K    \r\n", "R8");
        chk(proto_err == 0, "R9", "strobe handshake errors", proto_err, 0);
        release_cpu();
        inta_n = 1'b1;
    endtask

    // R1: reset in the middle of a trace
    task automatic test_reset_mid();
        slow_sink = 1;
        bus_cycle(3'b100, 8'h33, 8'h44, 8'h55);
        chk(ready == 1'b0, "R3", "stop before reset", ready, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(ready == 1'b1, "R1", "reset releases", ready, 1);
        chk(tx_send == 1'b0, "R1", "no strobe in reset", tx_send, 0);
        rst = 1'b0;
        tick(2);
        slow_sink = 0;
    endtask

    initial begin
        test_reset();
        test_zero_mask();
        test_trace_slow();
        test_no_refreeze();
        test_fast_second();
        test_reset_mid();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule